// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block holds the 32-bit floating-point status and control word next to a floating-point datapath. Each cycle it can take one of two things. The first is a completion report from the datapath: the exception conditions raised, the rounding indicators and the result class or compare outcome. The second is an explicit register-manipulation command. Exception flags accumulate and are never dropped by instruction reports. A first-occurrence summary is raised only when a flag newly turns on. Two further summaries, invalid-operation and enabled-exception, are pure functions of the stored flags and enables. They cannot be written.

Software-style commands are driven on the command port:
- copy one 4-bit field out, which also clears the exception bits it contains;
- write any set of fields from a 32-bit word;
- write a 4-bit immediate into one field;
- set or clear a single bit.

The full word is always visible on an output, together with an interrupt request that follows the enabled-exception summary.

Bits are numbered big-endian: bit n of the register appears on `fpsr[31-n]`. Field n covers bits 4n to 4n+3.

Top module: `fp_status_unit`

## Requirements
- R1: After synchronous reset, `fpsr` is all zeros and `fp_irq` is 0.
- R2: An instruction report ORs `ins_exc` into the sticky bits 3 to 12 (`ins_exc[9]` is bit 3, overflow, down to `ins_exc[0]` at bit 12, invalid compare). An instruction report never clears a sticky bit.
- R3: Bit 0 (first-occurrence summary) is set by an instruction report only when at least one sticky bit goes from 0 to 1 in that report. Otherwise the report leaves bit 0 unchanged.
- R4: Bit 2 always equals the OR of bits 7 to 12. Explicit writes to bit 2 have no effect.
- R5: Bit 1 equals (bit2&bit24)|(bit3&bit25)|(bit4&bit26)|(bit5&bit27)|(bit6&bit28). `fp_irq` equals bit 1. Explicit writes to bit 1 have no effect.
- R6: Command code 0 (copy) drives `copy_data` with field `op_field` of the current word in the same cycle, where `copy_data[3]` is bit 4n. At the clock edge it clears the exception bits (0 and 3 to 12) inside that field and leaves every other bit unchanged.
- R7: Command code 1 (masked write) loads field n from the same positions of `op_data` (laid out like `fpsr`) for every n with `op_mask[n]`=1.
- R8: Command code 2 (immediate) loads `op_imm` into field `op_field`, with `op_imm[3]` going to bit 4n.
- R9: Command codes 3 and 4 set and clear, respectively, bit `op_bit`, which is a big-endian bit number.
- R10: An instruction report with `ins_rnd`=1 overwrites bit 13 with `ins_fr` and bit 14 with `ins_fi`. With `ins_rnd`=0, both bits hold their values.
- R11: A non-compare report (`ins_cmp`=0) writes `ins_fprf` into bits 15 to 19, with `ins_fprf[4]` going to bit 15. A compare report sets exactly one of bits 16 to 19 (`ins_rel` 0=less, 1=greater, 2=equal, 3=unordered, selecting bits 16, 17, 18 and 19 in turn) and leaves bit 15 unchanged.
- R12: When `op_valid` is 1, the instruction report in that cycle is discarded. Command codes 5 to 7 change nothing.
- R13: Bits 24 to 31 (five enables and three control bits) are plain read/write storage. Bits 20 to 23 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction report strobe |
| ins_exc | input | 10 | Raised exception conditions, bit 3 first at MSB |
| ins_rnd | input | 1 | Report comes from a rounding instruction |
| ins_fr | input | 1 | Fraction was incremented |
| ins_fi | input | 1 | Fraction inexact |
| ins_cmp | input | 1 | Report comes from a compare |
| ins_rel | input | 2 | Compare outcome code |
| ins_fprf | input | 5 | Result class and condition flags |
| op_valid | input | 1 | Command strobe |
| op_kind | input | 3 | Command code |
| op_field | input | 3 | Field number for copy and immediate |
| op_mask | input | 8 | Field select for masked write, bit n = field n |
| op_data | input | 32 | Masked-write data in register layout |
| op_imm | input | 4 | Immediate field value |
| op_bit | input | 5 | Big-endian bit number for set and clear |
| copy_data | output | 4 | Selected field of the current word |
| fpsr | output | 32 | Full register, bit n on fpsr[31-n] |
| fp_irq | output | 1 | Enabled-exception request |

## Verification
The bench re-raises a flag that is already set after the summary bit was cleared by hand. A design that sets the summary on any raised flag, rather than on a new one, ends with bit 0 at 1. It copies field 1 out of a word that has all flags set. A copy that clears a misaligned nibble, or that misses the non-sticky neighbours, disturbs bits 3 or 8 and leaves bits 4 to 7 set. It toggles an enable under a standing flag. It also drives a command and a report in the same cycle, so a wrong priority lets the report's flag through. A reference model then compares the whole word after every random mix of reports and commands.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

    localparam int REG_W      = 32;
    localparam int FLD_W      = 4;
    localparam int NUM_FIELDS = REG_W / FLD_W;
    localparam int FSEL_W     = $clog2(NUM_FIELDS);
    localparam int BSEL_W     = $clog2(REG_W);
    localparam int EXC_N      = 10;
    localparam int SUM_N      = 5;

    // vector index of big-endian bit n is REG_W-1-n
    localparam int P_FX     = REG_W - 1 - 0;
    localparam int P_FEX    = REG_W - 1 - 1;
    localparam int P_VX     = REG_W - 1 - 2;
    localparam int P_OX     = REG_W - 1 - 3;
    localparam int P_UX     = REG_W - 1 - 4;
    localparam int P_ZX     = REG_W - 1 - 5;
    localparam int P_XX     = REG_W - 1 - 6;
    localparam int P_VXSNAN = REG_W - 1 - 7;
    localparam int P_VXVC   = REG_W - 1 - 12;
    localparam int P_FR     = REG_W - 1 - 13;
    localparam int P_FI     = REG_W - 1 - 14;
    localparam int P_CLS    = REG_W - 1 - 15;
    localparam int P_FL     = REG_W - 1 - 16;
    localparam int P_FU     = REG_W - 1 - 19;
    localparam int P_RS_HI  = REG_W - 1 - 20;
    localparam int P_RS_LO  = REG_W - 1 - 23;
    localparam int P_VE     = REG_W - 1 - 24;
    localparam int P_XE     = REG_W - 1 - 28;

    localparam logic [REG_W-1:0] ONE_W     = {{(REG_W-1){1'b0}}, 1'b1};
    localparam logic [REG_W-1:0] STICKY_M  = ((ONE_W << EXC_N) - ONE_W) << P_VXVC;
    localparam logic [REG_W-1:0] EXC_M     = STICKY_M | (ONE_W << P_FX);
    localparam logic [REG_W-1:0] DERIVED_M = (ONE_W << P_FEX) | (ONE_W << P_VX);
    localparam logic [REG_W-1:0] RSVD_M    = ((ONE_W << FLD_W) - ONE_W) << P_RS_LO;
    localparam logic [REG_W-1:0] WR_M      = ~(DERIVED_M | RSVD_M);

    typedef enum logic [2:0] {
        OP_COPY  = 3'd0,
        OP_WMASK = 3'd1,
        OP_WIMM  = 3'd2,
        OP_SETB  = 3'd3,
        OP_CLRB  = 3'd4
    } op_kind_e;

    typedef struct packed {
        logic [EXC_N-1:0] exc;
        logic             rnd;
        logic             fr;
        logic             fi;
        logic             cmp;
        logic [1:0]       rel;
        logic [4:0]       fprf;
    } ins_upd_t;

    typedef struct packed {
        op_kind_e          kind;
        logic [FSEL_W-1:0] field;
        logic [NUM_FIELDS-1:0] mask;
        logic [REG_W-1:0]  data;
        logic [FLD_W-1:0]  imm;
        logic [BSEL_W-1:0] bitn;
    } op_cmd_t;

    function automatic logic [REG_W-1:0] field_mask(input logic [FSEL_W-1:0] f);
        logic [REG_W-1:0] top;
        top = ((ONE_W << FLD_W) - ONE_W) << (REG_W - FLD_W);
        return top >> (FLD_W * int'(f));
    endfunction

    function automatic logic [3:0] rel_onehot(input logic [1:0] r);
        return 4'b1000 >> r;
    endfunction

endpackage

// File: rtl/fp_ins_merge.sv
module fp_ins_merge
    import fp_status_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  ins_upd_t         upd,
    output logic [REG_W-1:0] nxt
);
    logic [EXC_N-1:0] fresh;

    always_comb begin
        nxt   = cur;
        fresh = upd.exc & ~cur[P_OX:P_VXVC];
        nxt[P_OX:P_VXVC] = cur[P_OX:P_VXVC] | upd.exc;
        if (|fresh) begin
            nxt[P_FX] = 1'b1;
        end
        if (upd.rnd) begin
            nxt[P_FR] = upd.fr;
            nxt[P_FI] = upd.fi;
        end
        if (upd.cmp) begin
            nxt[P_FL:P_FU] = rel_onehot(upd.rel);
        end else begin
            nxt[P_CLS:P_FU] = upd.fprf;
        end
    end
endmodule

// File: rtl/fp_explicit_ops.sv
module fp_explicit_ops
    import fp_status_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] full,
    input  op_cmd_t          cmd,
    output logic [REG_W-1:0] nxt,
    output logic [FLD_W-1:0] copy_data
);
    logic [REG_W-1:0] wmask;
    logic [REG_W-1:0] fmask;
    logic [REG_W-1:0] bmask;
    logic [REG_W-1:0] imm_vec;
    logic [REG_W-1:0] sel;
    logic [REG_W-1:0] shifted;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        assign wmask[REG_W-1-FLD_W*g -: FLD_W] = {FLD_W{cmd.mask[g]}};
    end

    always_comb begin
        fmask   = field_mask(cmd.field);
        bmask   = (ONE_W << (REG_W - 1)) >> cmd.bitn;
        imm_vec = {NUM_FIELDS{cmd.imm}};
        shifted = full << (FLD_W * int'(cmd.field));
        copy_data = shifted[REG_W-1 -: FLD_W];
        sel = '0;
        nxt = cur;
        case (cmd.kind)
            OP_COPY:  nxt = cur & ~(fmask & EXC_M);
            OP_WMASK: begin
                sel = wmask & WR_M;
                nxt = (cur & ~sel) | (cmd.data & sel);
            end
            OP_WIMM:  begin
                sel = fmask & WR_M;
                nxt = (cur & ~sel) | (imm_vec & sel);
            end
            OP_SETB:  nxt = cur | (bmask & WR_M);
            OP_CLRB:  nxt = cur & ~(bmask & WR_M);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/fp_summary.sv
module fp_summary
    import fp_status_pkg::*;
(
    input  logic [REG_W-1:0] stored,
    output logic [REG_W-1:0] full,
    output logic             fex
);
    logic             vx;
    logic [SUM_N-1:0] srcs;
    logic [SUM_N-1:0] ens;
    logic [SUM_N-1:0] hits;

    assign vx   = |stored[P_VXSNAN:P_VXVC];
    assign srcs = {vx, stored[P_OX], stored[P_UX], stored[P_ZX], stored[P_XX]};
    assign ens  = stored[P_VE:P_XE];

    for (genvar g = 0; g < SUM_N; g++) begin : g_hit
        assign hits[g] = srcs[g] & ens[g];
    end

    assign fex = |hits;

    always_comb begin
        full = stored & ~(DERIVED_M | RSVD_M);
        full[P_FEX] = fex;
        full[P_VX]  = vx;
    end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fp_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_valid,
    input  logic [9:0]  ins_exc,
    input  logic        ins_rnd,
    input  logic        ins_fr,
    input  logic        ins_fi,
    input  logic        ins_cmp,
    input  logic [1:0]  ins_rel,
    input  logic [4:0]  ins_fprf,
    input  logic        op_valid,
    input  logic [2:0]  op_kind,
    input  logic [2:0]  op_field,
    input  logic [7:0]  op_mask,
    input  logic [31:0] op_data,
    input  logic [3:0]  op_imm,
    input  logic [4:0]  op_bit,
    output logic [3:0]  copy_data,
    output logic [31:0] fpsr,
    output logic        fp_irq
);
    logic [REG_W-1:0] st_q;
    logic [REG_W-1:0] st_d;
    logic [REG_W-1:0] ins_nxt;
    logic [REG_W-1:0] op_nxt;
    logic [REG_W-1:0] full;
    logic             fex;
    ins_upd_t         upd;
    op_cmd_t          cmd;

    assign upd = '{exc: ins_exc, rnd: ins_rnd, fr: ins_fr, fi: ins_fi,
                   cmp: ins_cmp, rel: ins_rel, fprf: ins_fprf};
    assign cmd = '{kind: op_kind_e'(op_kind), field: op_field, mask: op_mask,
                   data: op_data, imm: op_imm, bitn: op_bit};

    fp_summary u_sum (
        .stored (st_q),
        .full   (full),
        .fex    (fex)
    );

    fp_ins_merge u_ins (
        .cur (st_q),
        .upd (upd),
        .nxt (ins_nxt)
    );

    fp_explicit_ops u_ops (
        .cur       (st_q),
        .full      (full),
        .cmd       (cmd),
        .nxt       (op_nxt),
        .copy_data (copy_data)
    );

    always_comb begin
        if (op_valid) begin
            st_d = op_nxt;
        end else if (ins_valid) begin
            st_d = ins_nxt;
        end else begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d & WR_M;
        end
    end

    assign fpsr   = full;
    assign fp_irq = fex;
endmodule

// File: rtl/fp_status_chk.sv
module fp_status_chk
    import fp_status_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        ins_valid,
    input logic [9:0]  ins_exc,
    input logic        ins_rnd,
    input logic        ins_fr,
    input logic        ins_fi,
    input logic        ins_cmp,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic [2:0]  op_field,
    input logic [31:0] fpsr,
    input logic        fp_irq
);
    logic ins_only;
    logic fresh;
    assign ins_only = ins_valid && !op_valid;
    assign fresh    = |(ins_exc & ~fpsr[P_OX:P_VXVC]);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (fpsr == '0 && !fp_irq)); // R1

    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (rst)
        ins_only |=> ((fpsr[P_OX:P_VXVC] & ($past(fpsr[P_OX:P_VXVC]) | $past(ins_exc)))
                      == ($past(fpsr[P_OX:P_VXVC]) | $past(ins_exc)))); // R2

    AST_FX_ON_NEW: assert property (@(posedge clk) disable iff (rst)
        (ins_only && fresh) |=> fpsr[P_FX]); // R3

    AST_FX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ins_only && !fresh) |=> $stable(fpsr[P_FX])); // R3

    AST_COPY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd0) |=>
            ((fpsr & $past(field_mask(op_field)) & EXC_M) == '0)); // R6

    AST_ROUND_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ins_only && ins_rnd) |=> (fpsr[P_FR:P_FI] == {$past(ins_fr), $past(ins_fi)})); // R10

    AST_ROUND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ins_only && !ins_rnd) |=> $stable(fpsr[P_FR:P_FI])); // R10

    AST_CMP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (ins_only && ins_cmp) |=> ($countones(fpsr[P_FL:P_FU]) == 1)); // R11

    AST_CMD_WINS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd0 && ins_valid && ins_rnd) |=> $stable(fpsr[P_FR:P_FI])); // R12

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        fpsr[P_RS_HI:P_RS_LO] == '0); // R13
endmodule

bind fp_status_unit fp_status_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_exc   (ins_exc),
    .ins_rnd   (ins_rnd),
    .ins_fr    (ins_fr),
    .ins_fi    (ins_fi),
    .ins_cmp   (ins_cmp),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_field  (op_field),
    .fpsr      (fpsr),
    .fp_irq    (fp_irq)
);

// File: tb/fp_status_unit_tb_top.sv
module fp_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [9:0]  ins_exc = '0;
    logic        ins_rnd = 1'b0, ins_fr = 1'b0, ins_fi = 1'b0, ins_cmp = 1'b0;
    logic [1:0]  ins_rel = '0;
    logic [4:0]  ins_fprf = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0, op_field = '0;
    logic [7:0]  op_mask = '0;
    logic [31:0] op_data = '0;
    logic [3:0]  op_imm = '0;
    logic [4:0]  op_bit = '0;
    logic [3:0]  copy_data;
    logic [31:0] fpsr;
    logic        fp_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] model = '0;

    always #5 clk = ~clk;

    fp_status_unit dut_i (.*);

    function automatic bit writable(int b);
        return !(b == 1 || b == 2 || (b >= 20 && b <= 23));
    endfunction

    function automatic logic [31:0] full_of(logic [31:0] st);
        logic [31:0] r = st;
        logic vx = 1'b0;
        logic fex;
        for (int b = 7; b <= 12; b++) vx |= st[31-b];
        fex = (vx & st[31-24]) | (st[31-3] & st[31-25]) | (st[31-4] & st[31-26]) |
              (st[31-5] & st[31-27]) | (st[31-6] & st[31-28]);
        r[31-1] = fex;
        r[31-2] = vx;
        return r;
    endfunction

    function automatic logic [31:0] next_of(logic [31:0] st);
        logic [31:0] r = st;
        bit newflag = 0;
        int b;
        if (op_valid) begin
            case (op_kind)
                3'd0: for (int k = 0; k < 4; k++) begin
                    b = 4*op_field + k;
                    if (b == 0 || (b >= 3 && b <= 12)) r[31-b] = 1'b0;
                end
                3'd1: for (int n = 0; n < 32; n++)
                    if (op_mask[n/4] && writable(n)) r[31-n] = op_data[31-n];
                3'd2: for (int k = 0; k < 4; k++) begin
                    b = 4*op_field + k;
                    if (writable(b)) r[31-b] = op_imm[3-k];
                end
                3'd3: if (writable(op_bit)) r[31-op_bit] = 1'b1;
                3'd4: if (writable(op_bit)) r[31-op_bit] = 1'b0;
                default: ;
            endcase
        end else if (ins_valid) begin
            for (int k = 0; k < 10; k++) begin
                if (ins_exc[9-k]) begin
                    if (!st[31-(3+k)]) newflag = 1;
                    r[31-(3+k)] = 1'b1;
                end
            end
            if (newflag) r[31] = 1'b1;
            if (ins_rnd) begin
                r[31-13] = ins_fr;
                r[31-14] = ins_fi;
            end
            if (ins_cmp) begin
                for (int j = 16; j <= 19; j++) r[31-j] = 1'b0;
                r[31-(16+ins_rel)] = 1'b1;
            end else begin
                for (int j = 0; j < 5; j++) r[31-(15+j)] = ins_fprf[4-j];
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; op_valid = 0;
    endtask

    // inputs already driven after a negedge; advance one cycle and check
    task automatic run(string tag);
        logic [31:0] nx;
        logic [31:0] fl;
        #1;
        if (op_valid && op_kind == 3'd0) begin
            fl = full_of(model);
            check("R6 copy_data", 32'(copy_data), 32'((fl << (4*op_field)) >> 28));
        end
        nx = next_of(model);
        @(posedge clk);
        #1;
        model = nx;
        check(tag, fpsr, full_of(model));
        check("R5 irq", 32'(fp_irq), 32'(full_of(model)[30]));
        @(negedge clk);
        idle();
    endtask

    task automatic cmd(logic [2:0] k, string tag);
        op_valid = 1; op_kind = k;
        run(tag);
    endtask

    task automatic rpt(logic [9:0] e, string tag);
        ins_valid = 1; ins_exc = e; ins_rnd = 0; ins_cmp = 0; ins_fprf = '0;
        run(tag);
    endtask

    string tags [8] = '{"R6 copy", "R7 masked", "R8 imm", "R9 set", "R9 clr",
                        "R12 nop", "R12 nop", "R12 nop"};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        check("R1 reset fpsr", fpsr, 32'h0);
        check("R1 reset irq", 32'(fp_irq), 32'h0);
        @(negedge clk);
        rst = 0;

        // R3: FX not raised again by a flag that is already set
        rpt(10'b10_0000_0000, "R2 raise OX");
        check("R3 FX set", 32'(fpsr[31]), 32'h1);
        op_bit = 5'd0; cmd(3'd4, "R9 clear FX");
        rpt(10'b10_0000_0000, "R3 repeat OX");
        check("R3 FX stays clear", 32'(fpsr[31]), 32'h0);

        // R5: enable toggling under a standing overflow flag
        op_bit = 5'd25; cmd(3'd3, "R13 set OE");
        check("R5 irq on enable", 32'(fp_irq), 32'h1);
        op_bit = 5'd25; cmd(3'd4, "R13 clr OE");
        check("R5 irq off", 32'(fp_irq), 32'h0);

        // R4 and R5: derived bits ignore writes
        op_mask = 8'hFF; op_data = 32'h0; cmd(3'd1, "R7 clear all");
        op_bit = 5'd2; cmd(3'd3, "R4 set VX");
        check("R4 VX ignored", 32'(fpsr[29]), 32'h0);
        op_bit = 5'd1; cmd(3'd3, "R5 set FEX");
        check("R5 FEX ignored", 32'(fpsr[30]), 32'h0);

        // R6: copy field 1 clears only bits 4..7
        rpt(10'h3FF, "R2 raise all");
        op_field = 3'd1; cmd(3'd0, "R6 copy f1");
        check("R6 bits4-7 cleared", 32'(fpsr[27:24]), 32'h0);
        check("R6 bit3 kept", 32'(fpsr[28]), 32'h1);
        check("R6 bits8-12 kept", 32'(fpsr[23:19]), 32'h1F);
        check("R4 VX after copy", 32'(fpsr[29]), 32'h1);

        // R12: command beats report
        op_mask = 8'hFF; op_data = 32'h0; cmd(3'd1, "R7 clear all");
        ins_valid = 1; ins_exc = 10'b01_0000_0000;
        op_bit = 5'd24; cmd(3'd3, "R12 both");
        check("R12 report dropped", 32'(fpsr[27]), 32'h0);

        // R11 compare, R8 immediate into control field
        ins_valid = 1; ins_exc = '0; ins_cmp = 1; ins_rel = 2'd2; ins_rnd = 0;
        run("R11 compare eq");
        check("R11 fpcc", 32'(fpsr[15:12]), 32'b0010);
        op_field = 3'd7; op_imm = 4'b1010; cmd(3'd2, "R8 imm f7");
        check("R13 control bits", 32'(fpsr[3:0]), 32'hA);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            ins_valid = ($urandom_range(0, 3) != 0);
            ins_exc   = ($urandom_range(0, 2) == 0) ? 10'($urandom) : 10'(1 << $urandom_range(0, 9));
            ins_rnd   = 1'($urandom); ins_fr = 1'($urandom); ins_fi = 1'($urandom);
            ins_cmp   = 1'($urandom); ins_rel = 2'($urandom); ins_fprf = 5'($urandom);
            op_valid  = (sel < 4);
            op_kind   = 3'($urandom_range(0, 7));
            op_field  = 3'($urandom); op_mask = 8'($urandom); op_data = $urandom;
            op_imm    = 4'($urandom); op_bit = 5'($urandom);
            if (op_valid) run(tags[op_kind]);
            else run("R2/R3/R10/R11 report");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule